// File: doc/BRIEF.md
# PHY Control-Port Register Target

This block is the PHY-side responder of a strobe-and-acknowledge control port. Each cycle it samples a 20-bit control word: four strobe bits and a 16-bit value. A single strobe held high is answered with an acknowledge in a status word once a fixed number of clock edges has passed. The acknowledge drops again once the strobe is released. An address-capture strobe latches the target address and a data-capture strobe latches the write data. A write strobe commits the latched data to the addressed register. A read strobe returns that register's contents in the status word while the acknowledge is high.

The target holds a few registers. A clock-reset register sits at 0x7F3F, with the PHY reset in bit 0. A read-only lane status register sits at 0x2003, with the receive-PLL-ready flag in bit 1. A small bank of scratch registers gives plain storage. A nonzero write to the clock-reset register resets the PHY model. That write receives no acknowledge, and it restarts a timer that holds the PLL-ready flag low for a programmable number of cycles. A master on the other side brings up the PHY with this sequence: capture address, capture data, write, then poll the lane status with reads.

Top module: `phyctl_target`

## Requirements
- R1: After a synchronous reset the status word is all zero and every scratch register reads 0.
- R2: The control word carries four strobes: bit 16 captures the address, bit 17 captures the data, bit 18 writes and bit 19 reads. A single strobe is sampled high on ACK_DLY consecutive rising edges. After the last of those edges the acknowledge (status bit 18) is 1. It stays 1 while that strobe is held, and it is 0 after the first edge that samples the strobe low.
- R3: When more than one strobe bit is set, no acknowledge is given, and no address, data or register is changed.
- R4: The address-capture strobe latches control bits 15:0 as the target address. The data-capture strobe latches control bits 15:0 as write data.
- R5: The write strobe stores the latched data in the register at the latched address. Scratch registers sit at SCR_BASE to SCR_BASE+SCR_N-1 and keep all 16 bits.
- R6: While the acknowledge of a read strobe is high, status bits 15:0 hold the addressed register's contents. Otherwise those bits are 0.
- R7: Unmapped addresses read 0, and writes to them are dropped. Writes to the lane status register at 0x2003 are dropped.
- R8: The clock-reset register at 0x7F3F stores the written value. A write of a nonzero value gets no acknowledge. A write of zero is acknowledged normally.
- R9: Lane status bit 1 (receive PLL ready) reads 0 from the committing edge of a nonzero clock-reset write, or from the last reset edge, until PLL_DLY further edges have passed. After that it reads 1. All other lane status bits read 0.
- R10: Status bits 17:16 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | 20 | Strobes in bits 19:16, value in bits 15:0 |
| status_word | output | 19 | Acknowledge in bit 18, read data in bits 15:0 |

## Verification
A strobe first applied before edge k is acted on at edge k+ACK_DLY-1, and the acknowledge and read data are visible right after that edge. The bench advances one edge at a time and samples on the falling edge. It checks that the acknowledge is still low after each earlier edge and is correct just after the committing edge. It then checks that the acknowledge falls after the first edge that samples the strobe low. The bench records the edge number of the committing reset write. The PLL flag in a read that commits at edge e is then expected to be 1 exactly when e minus that edge exceeds PLL_DLY.

// File: rtl/phyctl_pkg.sv
package phyctl_pkg;

    typedef logic [15:0] word_t;

    typedef enum logic [1:0] {
        OP_ADDR = 2'd0,
        OP_DATA = 2'd1,
        OP_WR   = 2'd2,
        OP_RD   = 2'd3
    } op_e;

    typedef struct packed {
        logic [3:0] strb;
        word_t      val;
    } ctl_t;

    typedef struct packed {
        logic  fire;
        op_e   op;
        word_t val;
    } cmd_t;

    localparam word_t      CLKRST_ADDR = 16'h7F3F;
    localparam word_t      LANE_ADDR   = 16'h2003;
    localparam int         PLL_BIT     = 1;
    localparam logic [3:0] STRB_RD     = 4'b1000;

    function automatic logic single_strobe(input logic [3:0] s);
        return (s != 4'b0000) && ((s & (s - 4'd1)) == 4'b0000);
    endfunction

    function automatic op_e strobe_op(input logic [3:0] s);
        op_e o;
        case (1'b1)
            s[0]:    o = OP_ADDR;
            s[1]:    o = OP_DATA;
            s[2]:    o = OP_WR;
            default: o = OP_RD;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/phyctl_strobe_track.sv
module phyctl_strobe_track
    import phyctl_pkg::*;
#(
    parameter int ACK_DLY = 2
) (
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl,
    input  logic suppress,
    output cmd_t cmd,
    output logic ack,
    output logic rd_active
);
    localparam int            CNT_W = $clog2(ACK_DLY + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(ACK_DLY);

    logic [3:0]       cur_q;
    logic [CNT_W-1:0] hcnt_q;
    logic             ack_q;

    logic             single, same, at_lim, fire;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        single = single_strobe(ctl.strb);
        same   = (ctl.strb == cur_q);
        at_lim = (hcnt_q == LIM);
        if (!same)       nxt = CNT_W'(1);
        else if (at_lim) nxt = hcnt_q;
        else             nxt = hcnt_q + CNT_W'(1);
        fire = single && (nxt == LIM) && !(same && at_lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            hcnt_q <= '0;
            ack_q  <= 1'b0;
        end else begin
            cur_q  <= ctl.strb;
            hcnt_q <= single ? nxt : '0;
            if (fire) ack_q <= !suppress;
            else      ack_q <= single && same && ack_q;
        end
    end

    assign cmd.fire  = fire;
    assign cmd.op    = strobe_op(ctl.strb);
    assign cmd.val   = ctl.val;
    assign ack       = ack_q;
    assign rd_active = ack_q && (cur_q == STRB_RD);

endmodule

// File: rtl/phyctl_pll_timer.sv
module phyctl_pll_timer #(
    parameter int PLL_DLY = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic ready
);
    localparam int               CW   = $clog2(PLL_DLY + 1);
    localparam logic [CW-1:0]    LOAD = CW'(PLL_DLY);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart)      cnt_q <= LOAD;
        else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
    end

    assign ready = (cnt_q == '0);

endmodule

// File: rtl/phyctl_regs.sv
module phyctl_regs
    import phyctl_pkg::*;
#(
    parameter int    SCR_N    = 4,
    parameter word_t SCR_BASE = 16'h0010
) (
    input  logic  clk,
    input  logic  rst,
    input  cmd_t  cmd,
    input  logic  pll_ready,
    output logic  suppress,
    output logic  pll_restart,
    output word_t rdata
);
    word_t            addr_q, data_q, rstreg_q, rdata_q, rd_val;
    word_t            scr_q [SCR_N];
    logic [SCR_N-1:0] hit;
    logic             wr_go;

    assign wr_go       = cmd.fire && (cmd.op == OP_WR);
    assign suppress    = wr_go && (addr_q == CLKRST_ADDR) && (data_q != '0);
    assign pll_restart = suppress;

    for (genvar g = 0; g < SCR_N; g++) begin : g_scr
        assign hit[g] = (addr_q == word_t'(SCR_BASE + g));
        always_ff @(posedge clk) begin
            if (rst)                scr_q[g] <= '0;
            else if (wr_go && hit[g]) scr_q[g] <= data_q;
        end
    end

    always_comb begin
        rd_val = '0;
        if (addr_q == CLKRST_ADDR) rd_val = rstreg_q;
        if (addr_q == LANE_ADDR)   rd_val[PLL_BIT] = pll_ready;
        for (int i = 0; i < SCR_N; i++)
            if (hit[i]) rd_val = scr_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            data_q   <= '0;
            rstreg_q <= '0;
            rdata_q  <= '0;
        end else if (cmd.fire) begin
            case (cmd.op)
                OP_ADDR: addr_q  <= cmd.val;
                OP_DATA: data_q  <= cmd.val;
                OP_RD:   rdata_q <= rd_val;
                default: if (addr_q == CLKRST_ADDR) rstreg_q <= data_q;
            endcase
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/phyctl_target.sv
module phyctl_target
    import phyctl_pkg::*;
#(
    parameter int    ACK_DLY  = 2,
    parameter int    PLL_DLY  = 24,
    parameter int    SCR_N    = 4,
    parameter word_t SCR_BASE = 16'h0010
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [19:0] ctl_word,
    output logic [18:0] status_word
);
    ctl_t  ctl;
    cmd_t  cmd;
    logic  ack, rd_active, suppress, pll_restart, pll_ready;
    word_t rdata;

    assign ctl.strb = ctl_word[19:16];
    assign ctl.val  = ctl_word[15:0];

    phyctl_strobe_track #(.ACK_DLY(ACK_DLY)) u_track (
        .clk(clk), .rst(rst), .ctl(ctl), .suppress(suppress),
        .cmd(cmd), .ack(ack), .rd_active(rd_active)
    );

    phyctl_regs #(.SCR_N(SCR_N), .SCR_BASE(SCR_BASE)) u_regs (
        .clk(clk), .rst(rst), .cmd(cmd), .pll_ready(pll_ready),
        .suppress(suppress), .pll_restart(pll_restart), .rdata(rdata)
    );

    phyctl_pll_timer #(.PLL_DLY(PLL_DLY)) u_pll (
        .clk(clk), .rst(rst), .restart(pll_restart), .ready(pll_ready)
    );

    assign status_word = {ack, 2'b00, (rd_active ? rdata : 16'h0000)};

endmodule

// File: rtl/phyctl_target_chk.sv
module phyctl_target_chk (
    input logic        clk,
    input logic        rst,
    input logic [19:0] ctl_word,
    input logic [18:0] status_word
);
    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        status_word[17:16] == 2'b00);

    // R2
    ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_word[19:16] == 4'b0000) |=> !status_word[18]);

    // R2
    ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status_word[18]) |-> ($countones($past(ctl_word[19:16])) == 1));

    // R3
    multi_noack_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(ctl_word[19:16]) > 1) |=> !status_word[18]);

    // R6
    rdata_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (status_word[15:0] != 16'h0000) |->
            (status_word[18] && ($past(ctl_word[19:16]) == 4'b1000)));

endmodule

bind phyctl_target phyctl_target_chk u_chk (
    .clk(clk), .rst(rst), .ctl_word(ctl_word), .status_word(status_word)
);

// File: tb/tb_phyctl_target.sv
module tb_phyctl_target;
    localparam int          ACK_DLY  = 2;
    localparam int          PLL_DLY  = 24;
    localparam int          SCR_N    = 4;
    localparam logic [15:0] SCR_BASE = 16'h0010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] ctl = '0;
    logic [18:0] st;

    int checks = 0, errors = 0, ecount = 0, pll_ref = 0, last_fire = 0;

    always #5 clk = ~clk;

    phyctl_target #(.ACK_DLY(ACK_DLY), .PLL_DLY(PLL_DLY), .SCR_N(SCR_N),
                    .SCR_BASE(SCR_BASE)) dut (
        .clk(clk), .rst(rst), .ctl_word(ctl), .status_word(st));

    task automatic tick();
        @(posedge clk);
        ecount++;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int i, input bit inv);
        return 16'hA5C3 ^ (16'(i) * 16'h1111) ^ (inv ? 16'hFFFF : 16'h0000);
    endfunction

    // one strobe: bit s (0 addr, 1 data, 2 write, 3 read)
    task automatic op(input int s, input logic [15:0] v, input bit exp_ack,
                      output logic [15:0] rd);
        ctl = (20'd1 << (16 + s)) | {4'b0, v};
        for (int k = 0; k < ACK_DLY - 1; k++) begin
            tick();
            chk("R2 early", {31'b0, st[18]}, 0);
        end
        tick();
        last_fire = ecount;
        chk(exp_ack ? "R2 rise" : "R8 noack", {31'b0, st[18]}, {31'b0, exp_ack});
        chk("R10", {30'b0, st[17:16]}, 0);
        rd = st[15:0];
        if (s != 3) chk("R6 idle data", {16'b0, st[15:0]}, 0);
        tick();
        chk("R2 hold", {31'b0, st[18]}, {31'b0, exp_ack});
        ctl = '0;
        tick();
        chk("R2 fall", {31'b0, st[18]}, 0);
        chk("R6 after", {16'b0, st[15:0]}, 0);
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d, input bit exp_ack);
        logic [15:0] x;
        op(0, a, 1'b1, x);
        op(1, d, 1'b1, x);
        op(2, 16'h0, exp_ack, x);
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] v);
        logic [15:0] x;
        op(0, a, 1'b1, x);
        op(3, 16'h0, 1'b1, v);
    endtask

    function automatic logic [15:0] lane_exp(input int fire_edge);
        return (fire_edge - pll_ref > PLL_DLY) ? 16'h0002 : 16'h0000;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] unm [5];
        unm = '{16'h0000, SCR_BASE - 16'd1, SCR_BASE + 16'(SCR_N), 16'h2002, 16'hFFFF};

        repeat (3) tick();
        pll_ref = ecount;
        rst = 1'b0;
        chk("R1 status", {13'b0, st}, 0);
        rd(LANE_ADDR_TB(), v);
        chk("R9 after reset", {16'b0, v}, {16'b0, lane_exp(last_fire)});
        for (int i = 0; i < SCR_N; i++) begin
            rd(SCR_BASE + 16'(i), v);
            chk("R1 scratch", {16'b0, v}, 0);
        end

        // R4 R5 scratch sweeps with two patterns
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < SCR_N; i++) wr(SCR_BASE + 16'(i), pat(i, p[0]), 1'b1);
            for (int i = 0; i < SCR_N; i++) begin
                rd(SCR_BASE + 16'(i), v);
                chk("R5 scratch", {16'b0, v}, {16'b0, pat(i, p[0])});
            end
        end

        // R7 unmapped addresses
        for (int i = 0; i < 5; i++) begin
            wr(unm[i], 16'hBEEF, 1'b1);
            rd(unm[i], v);
            chk("R7 unmapped", {16'b0, v}, 0);
        end
        for (int i = 0; i < SCR_N; i++) begin
            rd(SCR_BASE + 16'(i), v);
            chk("R7 scratch intact", {16'b0, v}, {16'b0, pat(i, 1'b1)});
        end
        wr(16'h2003, 16'hFFFF, 1'b1);
        rd(16'h2003, v);
        chk("R7 lane write dropped", {16'b0, v}, {16'b0, lane_exp(last_fire)});

        // R8 clock-reset register
        wr(16'h7F3F, 16'h0000, 1'b1);
        rd(16'h7F3F, v);
        chk("R8 zero write", {16'b0, v}, 0);
        wr(16'h7F3F, 16'h0001, 1'b0);
        pll_ref = last_fire;
        rd(16'h7F3F, v);
        chk("R8 readback", {16'b0, v}, 16'h0001);
        // R9 poll PLL ready across the window
        for (int k = 0; k < 6; k++) begin
            rd(16'h2003, v);
            chk("R9 pll poll", {16'b0, v}, {16'b0, lane_exp(last_fire)});
        end
        wr(16'h7F3F, 16'h0004, 1'b0);
        pll_ref = last_fire;
        rd(16'h2003, v);
        chk("R9 restart", {16'b0, v}, {16'b0, lane_exp(last_fire)});

        // R3 multiple strobes ignored
        wr(SCR_BASE, 16'h5A5A, 1'b1);
        ctl = 20'h30000 | {4'b0, SCR_BASE + 16'd3};
        for (int k = 0; k < ACK_DLY + 3; k++) begin
            tick();
            chk("R3 no ack", {31'b0, st[18]}, 0);
        end
        ctl = 20'hC0000;
        for (int k = 0; k < ACK_DLY + 2; k++) begin
            tick();
            chk("R3 no ack wr+rd", {31'b0, st[18]}, 0);
        end
        ctl = '0;
        tick();
        op(2, 16'h0, 1'b1, v);
        rd(SCR_BASE, v);
        chk("R3 addr/data kept", {16'b0, v}, 16'h5A5A);
        rd(SCR_BASE + 16'd3, v);
        chk("R3 other intact", {16'b0, v}, {16'b0, pat(3, 1'b1)});

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [15:0] LANE_ADDR_TB();
        return 16'h2003;
    endfunction

endmodule